// File: doc/BRIEF.md
# Interrupt Status, Enable and Mask Unit

This block collects event pulses from the receive and transmit paths of a CAN FD style controller and turns them into one level-sensitive interrupt line. Each source has a fixed bit in a 32-bit status register. An event that is not masked sets its status bit, and the bit stays set until software writes a 1 to it. A separate enable register selects which status bits drive the interrupt output.

The enable and mask registers have no direct write address. Each has a set address that ORs the written word into the register and a clear address that clears every bit written as 1. Reading either address of the pair returns the register. The mask acts at the input: a masked event never reaches status, so it is lost and does not wait until it is unmasked. The buffer-not-empty source is a level derived from the stored receive frame count. While the count is non-zero it re-asserts in every cycle.

Top module: `irq_status_unit`

## Requirements
- R1: Reset clears status, enable and mask to zero. While the registers are zero, `irq_o` is low and every register reads as zero.
- R2: A write to word address 0 (status) clears each status bit that is 1 in `wr_data`. Bits written as 0 keep their value.
- R3: A write to address 1 (enable set) ORs `wr_data` into the enable register.
- R4: A write to address 2 (enable clear) clears each enable bit that is 1 in `wr_data`.
- R5: Address 3 (mask set) ORs `wr_data` into the mask register. Address 4 (mask clear) clears the mask bits that are 1 in `wr_data`.
- R6: Reading address 1 or address 2 returns the enable register. Reading address 3 or address 4 returns the mask register. Reading address 0 returns status.
- R7: An event whose mask bit is 1 at the clock edge does not set status. Clearing that mask bit later does not make the event appear.
- R8: An unmasked pulse on `evt_i[k]` sets status bit k at the next edge. The positions are: receive 0, receive-full 1, data overrun 2, transmit done 3, transmit buffer change 4.
- R9: `irq_o` is high exactly when the bitwise AND of status and enable is non-zero. It follows every register update without added delay.
- R10: While `rx_frame_cnt` is non-zero and mask bit 5 is 0, status bit 5 (buffer not empty) is set at every edge.
- R11: If a status clear and an unmasked event hit the same bit in the same cycle, the bit stays set.
- R12: Addresses 5 to 7 read as zero, and a write to them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| evt_i | input | 5 | Event pulses: receive, receive-full, overrun, transmit done, buffer change |
| rx_frame_cnt | input | 8 | Stored receive frame count |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two functions can land on the same status bit in the same cycle: the write-one-to-clear from software and the latching of a new event. The bench provokes this by writing 1 to a status bit while the matching event pulse is high. It also does it by clearing bit 5 while the frame count stays non-zero. The status is then read back and must still show the bit. A second collision is a mask write in the same cycle as an event. In that case the mask value held before the edge decides whether the event latches, and the reference model is compared on every clock to check it.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_W   = 32;
    localparam int ADR_W   = 3;
    localparam int PULSE_N = 5;
    localparam int CNT_W   = 8;

    localparam logic [ADR_W-1:0] ADR_STAT    = 3'd0;
    localparam logic [ADR_W-1:0] ADR_EN_SET  = 3'd1;
    localparam logic [ADR_W-1:0] ADR_EN_CLR  = 3'd2;
    localparam logic [ADR_W-1:0] ADR_MSK_SET = 3'd3;
    localparam logic [ADR_W-1:0] ADR_MSK_CLR = 3'd4;

    localparam int BIT_RX    = 0;
    localparam int BIT_RXFUL = 1;
    localparam int BIT_OVR   = 2;
    localparam int BIT_TXOK  = 3;
    localparam int BIT_TXBCH = 4;
    localparam int BIT_BNE   = 5;
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic [W-1:0] bits;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) st_d.bits = st_q.bits | wdata;
        if (clr_we) st_d.bits = st_d.bits & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.bits;
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] src,
    input  logic [W-1:0] mask,
    output logic [W-1:0] status
);
    typedef struct packed {
        logic [W-1:0] bits;
    } stat_t;

    stat_t st_d, st_q;
    logic [W-1:0] clr_bits;
    logic [W-1:0] new_bits;

    always_comb begin
        clr_bits  = clr_we ? wdata : '0;
        new_bits  = src & ~mask;
        st_d.bits = (st_q.bits & ~clr_bits) | new_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int AW    = ADR_W,
    parameter int NP    = PULSE_N,
    parameter int CW    = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic [NP-1:0] evt_i,
    input  logic [CW-1:0] rx_frame_cnt,
    output logic          irq_o
);
    localparam int NSC = 2;

    logic [W-1:0] src_w;
    logic [W-1:0] status_w;
    logic [W-1:0] enable_w;
    logic [W-1:0] mask_w;
    logic [W-1:0] sc_val [NSC];
    logic [NSC-1:0] sc_set;
    logic [NSC-1:0] sc_clr;
    logic stat_clr;

    for (genvar s = 0; s < W; s++) begin : g_src
        if (s < NP) begin : g_pulse
            assign src_w[s] = evt_i[s];
        end else if (s == BIT_BNE) begin : g_level
            assign src_w[s] = |rx_frame_cnt;
        end else begin : g_none
            assign src_w[s] = 1'b0;
        end
    end

    always_comb begin
        stat_clr  = wr_en && (wr_addr == ADR_STAT);
        sc_set[0] = wr_en && (wr_addr == ADR_EN_SET);
        sc_clr[0] = wr_en && (wr_addr == ADR_EN_CLR);
        sc_set[1] = wr_en && (wr_addr == ADR_MSK_SET);
        sc_clr[1] = wr_en && (wr_addr == ADR_MSK_CLR);
    end

    for (genvar g = 0; g < NSC; g++) begin : g_sc
        irq_setclr_reg #(.W(W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (sc_set[g]),
            .clr_we (sc_clr[g]),
            .wdata  (wr_data),
            .value  (sc_val[g])
        );
    end

    assign enable_w = sc_val[0];
    assign mask_w   = sc_val[1];

    irq_status_latch #(.W(W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_we (stat_clr),
        .wdata  (wr_data),
        .src    (src_w),
        .mask   (mask_w),
        .status (status_w)
    );

    always_comb begin
        case (rd_addr)
            ADR_STAT:                 rd_data = status_w;
            ADR_EN_SET, ADR_EN_CLR:   rd_data = enable_w;
            ADR_MSK_SET, ADR_MSK_CLR: rd_data = mask_w;
            default:                  rd_data = '0;
        endcase
    end

    assign irq_o = |(status_w & enable_w);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [W-1:0]  wr_data,
    input logic [W-1:0]  src_vec,
    input logic [W-1:0]  stat_q,
    input logic [W-1:0]  en_q,
    input logic [W-1:0]  msk_q,
    input logic          irq_o
);
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0 && en_q == '0 && msk_q == '0 && !irq_o));

    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_STAT) |=>
        ((stat_q & $past(wr_data) & ~$past(src_vec & ~msk_q)) == '0));

    p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_EN_SET) |=>
        ((en_q & $past(wr_data)) == $past(wr_data)));

    p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_EN_CLR) |=> ((en_q & $past(wr_data)) == '0));

    p_mask_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & $past(msk_q)) == '0));

    p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(src_vec & ~msk_q)) == $past(src_vec & ~msk_q)));

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((stat_q & en_q) != '0));
endmodule

bind irq_status_unit irq_status_chk #(.W(W), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .src_vec (src_w),
    .stat_q  (status_w),
    .en_q    (enable_w),
    .msk_q   (mask_w),
    .irq_o   (irq_o)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [4:0]  evt_i = '0;
    logic [7:0]  rx_frame_cnt = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_stat = '0, m_en = '0, m_msk = '0;

    always #4 clk = ~clk;

    irq_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_i(evt_i), .rx_frame_cnt(rx_frame_cnt), .irq_o(irq_o)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:       return m_stat;
            3'd1, 3'd2: return m_en;
            3'd3, 3'd4: return m_msk;
            default:    return 32'h0;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [31:0] exp_rd;
        logic        exp_irq;
        exp_rd  = model_read(rd_addr);
        exp_irq = |(m_stat & m_en);
        checks++;
        if (rd_data !== exp_rd) begin
            fails++;
            $display("FAIL %s rd_data addr %0d: got %h expected %h", tag, rd_addr, rd_data, exp_rd);
        end
        checks++;
        if (irq_o !== exp_irq) begin
            fails++;
            $display("FAIL %s irq_o: got %b expected %b", tag, irq_o, exp_irq);
        end
    endtask

    // One cycle: drive at the falling edge, model the rising edge, compare at the next falling edge.
    task automatic step(input bit we, input logic [2:0] wa, input logic [31:0] wd,
                        input logic [4:0] ev, input logic [7:0] cnt,
                        input logic [2:0] ra, input string tag);
        logic [31:0] src;
        logic [31:0] clr;
        wr_en = we; wr_addr = wa; wr_data = wd;
        evt_i = ev; rx_frame_cnt = cnt; rd_addr = ra;
        @(posedge clk);
        src = {26'h0, (cnt != 0), ev};
        clr = (we && wa == 3'd0) ? wd : 32'h0;
        m_stat = (m_stat & ~clr) | (src & ~m_msk);
        if (we && wa == 3'd1) m_en  = m_en | wd;
        if (we && wa == 3'd2) m_en  = m_en & ~wd;
        if (we && wa == 3'd3) m_msk = m_msk | wd;
        if (we && wa == 3'd4) m_msk = m_msk & ~wd;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic look(input logic [2:0] ra, input string tag);
        step(1'b0, 3'd0, 32'h0, 5'h0, 8'h0, ra, tag);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        wr_en = 1'b0; evt_i = '0; rx_frame_cnt = '0;
        m_stat = '0; m_en = '0; m_msk = '0;
        @(negedge clk);
        @(negedge clk);
        for (int a = 0; a < 5; a++) begin
            rd_addr = a[2:0];
            #1 compare("R1");
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R3 / R6: enable set, read through both aliases
        step(1'b1, 3'd1, 32'h0000_00FF, 5'h0, 8'h0, 3'd1, "R3");
        look(3'd2, "R6");
        // R4: enable clear
        step(1'b1, 3'd2, 32'h0000_000F, 5'h0, 8'h0, 3'd1, "R4");

        // R8: receive pulse at bit 0, enable off there, no irq
        step(1'b0, 3'd0, 32'h0, 5'b00001, 8'h0, 3'd0, "R8");
        // R8 / R9: buffer-change pulse at bit 4, enabled, irq rises
        step(1'b0, 3'd0, 32'h0, 5'b10000, 8'h0, 3'd0, "R9");
        // R2: clear bit 4 only, bit 0 stays, irq falls
        step(1'b1, 3'd0, 32'h0000_0010, 5'h0, 8'h0, 3'd0, "R2");

        // R5 / R6: mask overrun bit, read both aliases
        step(1'b1, 3'd3, 32'h0000_0004, 5'h0, 8'h0, 3'd4, "R5");
        look(3'd3, "R6");
        // R7: masked overrun does not latch
        step(1'b0, 3'd0, 32'h0, 5'b00100, 8'h0, 3'd0, "R7");
        step(1'b1, 3'd4, 32'h0000_0004, 5'h0, 8'h0, 3'd3, "R5");
        look(3'd0, "R7");

        // R10: non-empty receive count sets bit 5
        step(1'b0, 3'd0, 32'h0, 5'h0, 8'd3, 3'd0, "R10");
        // R11: clearing bit 5 while the count stays non-zero keeps it set
        step(1'b1, 3'd0, 32'h0000_0020, 5'h0, 8'd3, 3'd0, "R11");
        step(1'b1, 3'd0, 32'h0000_0020, 5'h0, 8'd0, 3'd0, "R10");
        // R11: clear bit 0 with a receive pulse in the same cycle
        step(1'b1, 3'd0, 32'h0000_0001, 5'b00001, 8'h0, 3'd0, "R11");
        // R9: enabling bit 0 raises irq
        step(1'b1, 3'd1, 32'h0000_0001, 5'h0, 8'h0, 3'd0, "R9");

        // R12: unmapped addresses
        step(1'b1, 3'd6, 32'hFFFF_FFFF, 5'h0, 8'h0, 3'd6, "R12");
        look(3'd5, "R12");
        look(3'd7, "R12");
        look(3'd0, "R12");
        look(3'd1, "R12");

        // Mask write colliding with an event: the old mask decides (R7)
        step(1'b1, 3'd3, 32'h0000_0008, 5'b01000, 8'h0, 3'd0, "R7");
        step(1'b0, 3'd0, 32'h0, 5'b01000, 8'h0, 3'd0, "R7");

        // Mixed traffic against the reference model (R9)
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[3:1], {$urandom} & 32'h0000_00FF, r[8:4],
                 (r[9] ? r[17:10] : 8'h0), r[20:18], "R9");
        end

        // R1: reset after activity
        do_reset();
        look(3'd0, "R1");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule